// File: doc/BRIEF.md
# Block-Repeat DMA Channel

This is a single DMA channel that copies data in fixed-size blocks. Software loads a source address, a destination address, a unit count, a reload copy of that count, a block count and a control word. Each accepted trigger then runs one uninterrupted burst that copies the whole current block, one unit at a time. A unit is a byte or a 16-bit word. Each unit takes one read cycle on the memory port followed by one write cycle.

One side of the transfer is the block area and can be either the source or the destination. At the end of every block, the block-area address goes back to the value it had when that block began, and the unit count is refilled from its reload copy. The opposite address keeps advancing. A 16-bit block counter is decremented once per block. When it reaches zero, the channel clears its own enable bit and, if interrupts are enabled, raises an interrupt. The interrupt stays high until software writes the control word.

Triggers come from four timer event inputs or from an external active-low pin. A field in the control word selects the trigger source.

Top module: `blk_dma_engine`

## Requirements
- R1: After reset, all six registers read back zero, `busy` and `irq` are low, and the memory port neither reads nor writes.
- R2: An accepted trigger starts a burst of strictly alternating read and write cycles, two cycles per unit, with no gap, and `busy` stays high for exactly 2·N cycles, where N is the unit count. Each write carries the data read in the cycle before it.
- R3: Address mode field (control bits [4:3] for the source, [6:5] for the destination): 01 increments, 10 decrements, 00 and 11 hold. The step is 1 for bytes (control bit 7 = 0) and 2 for words (bit 7 = 1).
- R4: After the last unit of a block, the unit count (register 2) is refilled from the reload register (register 3).
- R5: After the last unit of a block, the block-area address returns to its value at the start of that block. The other address keeps its stepped value.
- R6: Control bit 2 selects the block area: 1 makes the source address (register 0) the block area, 0 makes the destination address (register 1) the block area.
- R7: The block count (register 4) is decremented once per completed block. While it is still nonzero, the channel returns to idle and waits for the next trigger.
- R8: When the block count reaches zero, hardware clears the enable bit (control bit 0). `irq` rises at that point only if control bit 1 is set.
- R9: Once `irq` is high, it stays high until a write to the control register (register 5).
- R10: Trigger select (control bits [10:8]): values 0 to 3 pick `trig_tmr[0..3]`, which are sampled high on a clock edge. Value 4 picks `trig_ext_n`, which triggers only on its high-to-low edge. Values 5 to 7 never trigger.
- R11: A trigger is ignored while the enable bit is clear or while a burst is running, including the burst's final write cycle.
- R12: The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 source, 1 destination, 2 unit count, 3 unit reload, 4 block count, 5 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, zero-extended |
| trig_tmr | input | 4 | Timer event triggers |
| trig_ext_n | input | 1 | External trigger, active on its falling edge |
| mem_addr | output | AW | Memory address: source during reads, destination during writes |
| mem_re | output | 1 | Memory read cycle |
| mem_we | output | 1 | Memory write cycle |
| mem_word | output | 1 | Access size: 1 for 16-bit word, 0 for byte |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, returned in the same cycle |
| busy | output | 1 | A burst is in progress |
| irq | output | 1 | Job-complete interrupt |

## Verification
Two events can fall in the same clock cycle here. The first is a new trigger arriving in the final write cycle of a burst, the same cycle in which the block count, the unit reload and the address restore all take effect. The bench provokes this by counting write strobes at the memory port and raising the selected timer input exactly during the last write. It also holds the trigger high in the first read cycle of the same burst. The collision is judged correct if exactly N writes appear, the block count falls by one and the block-area address is restored. A later clean trigger must then run the next block normally.

// File: rtl/blk_dma_engine.sv
module blk_dma_engine #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int UW = 8,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [3:0]    trig_tmr,
  input  logic          trig_ext_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic          mem_word,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2} st_t;

  st_t           st_q;
  logic [AW-1:0] src_q, dst_q, anchor_q;
  logic [UW-1:0] ucnt_q, urld_q;
  logic [BW-1:0] bcnt_q;
  logic [DW-1:0] data_q;
  logic          en_q, ie_q, bsrc_q, word_q, ext_q, irq_q;
  logic [1:0]    smode_q, dmode_q;
  logic [2:0]    tsel_q;

  logic ctl_wr, ext_fall, trig, start, last_unit, last_blk;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic w);
    logic [AW-1:0] inc;
    inc = {{(AW-2){1'b0}}, w, ~w};
    case (m)
      2'b01:   return a + inc;
      2'b10:   return a - inc;
      default: return a;
    endcase
  endfunction

  assign ctl_wr    = reg_we && (reg_addr == 3'd5);
  assign ext_fall  = ext_q && !trig_ext_n;
  assign trig      = tsel_q[2] ? (tsel_q[1:0] == 2'd0 && ext_fall) : trig_tmr[tsel_q[1:0]];
  assign start     = (st_q == S_IDLE) && en_q && trig;
  assign last_unit = (st_q == S_WR) && (ucnt_q == UW'(1));
  assign last_blk  = last_unit && (bcnt_q == BW'(1));

  assign busy      = (st_q != S_IDLE);
  assign irq       = irq_q;
  assign mem_re    = (st_q == S_RD);
  assign mem_we    = (st_q == S_WR);
  assign mem_word  = word_q;
  assign mem_addr  = (st_q == S_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(src_q);
      3'd1:    reg_rdata = 32'(dst_q);
      3'd2:    reg_rdata = 32'(ucnt_q);
      3'd3:    reg_rdata = 32'(urld_q);
      3'd4:    reg_rdata = 32'(bcnt_q);
      3'd5:    reg_rdata = {21'd0, tsel_q, word_q, dmode_q, smode_q, bsrc_q, ie_q, en_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      src_q <= '0; dst_q <= '0; anchor_q <= '0;
      ucnt_q <= '0; urld_q <= '0; bcnt_q <= '0; data_q <= '0;
      en_q <= 1'b0; ie_q <= 1'b0; bsrc_q <= 1'b0; word_q <= 1'b0;
      smode_q <= 2'b00; dmode_q <= 2'b00; tsel_q <= 3'd0;
      ext_q <= 1'b1; irq_q <= 1'b0;
    end else begin
      ext_q <= trig_ext_n;
      if (reg_we) begin
        case (reg_addr)
          3'd0: src_q  <= reg_wdata[AW-1:0];
          3'd1: dst_q  <= reg_wdata[AW-1:0];
          3'd2: ucnt_q <= reg_wdata[UW-1:0];
          3'd3: urld_q <= reg_wdata[UW-1:0];
          3'd4: bcnt_q <= reg_wdata[BW-1:0];
          3'd5: begin
            en_q    <= reg_wdata[0];
            ie_q    <= reg_wdata[1];
            bsrc_q  <= reg_wdata[2];
            smode_q <= reg_wdata[4:3];
            dmode_q <= reg_wdata[6:5];
            word_q  <= reg_wdata[7];
            tsel_q  <= reg_wdata[10:8];
            irq_q   <= 1'b0;
          end
          default: ;
        endcase
      end
      case (st_q)
        S_IDLE: if (start) begin
          anchor_q <= bsrc_q ? src_q : dst_q;
          st_q     <= S_RD;
        end
        S_RD: begin
          data_q <= word_q ? mem_rdata : {{(DW-8){1'b0}}, mem_rdata[7:0]};
          st_q   <= S_WR;
        end
        S_WR: begin
          src_q  <= (last_unit && bsrc_q)  ? anchor_q : step(src_q, smode_q, word_q);
          dst_q  <= (last_unit && !bsrc_q) ? anchor_q : step(dst_q, dmode_q, word_q);
          ucnt_q <= last_unit ? urld_q : ucnt_q - UW'(1);
          if (last_unit) begin
            bcnt_q <= bcnt_q - BW'(1);
            st_q   <= S_IDLE;
          end else begin
            st_q   <= S_RD;
          end
          if (last_blk) begin
            en_q <= 1'b0;
            if (ie_q) irq_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

module blk_dma_chk #(
  parameter int UW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic          busy,
  input logic          en,
  input logic          ie,
  input logic          irq,
  input logic          ctl_wr,
  input logic          mem_re,
  input logic          mem_we,
  input logic [UW-1:0] ucnt,
  input logic [UW-1:0] urld
);
  assert_no_rw_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));

  assert_start_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));

  assert_unit_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && ucnt == UW'(1)) |=> (ucnt == $past(urld)));

  assert_done_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en) && !$past(ctl_wr)) |-> (irq == $past(ie)));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ctl_wr));
endmodule

bind blk_dma_engine blk_dma_chk #(.UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .busy(busy), .en(en_q), .ie(ie_q),
  .irq(irq), .ctl_wr(ctl_wr), .mem_re(mem_re), .mem_we(mem_we),
  .ucnt(ucnt_q), .urld(urld_q)
);

// File: tb/tb_blk_dma_engine.sv
module tb_blk_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [3:0]  trig_tmr = 4'd0;
  logic        trig_ext_n = 1'b1;
  logic [23:0] mem_addr;
  logic        mem_re, mem_we, mem_word, busy, irq;
  logic [15:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem  [0:1023];
  logic [7:0] orig [0:1023];
  logic [9:0] wlog [0:63];
  int wcnt = 0;

  always #10 clk = ~clk;

  blk_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_tmr(trig_tmr),
    .trig_ext_n(trig_ext_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_word(mem_word), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .irq(irq)
  );

  always_comb begin
    if (mem_word) mem_rdata = {mem[{mem_addr[9:1], 1'b1}], mem[{mem_addr[9:1], 1'b0}]};
    else          mem_rdata = {8'h00, mem[mem_addr[9:0]]};
  end

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_word) begin
        mem[{mem_addr[9:1], 1'b0}] <= mem_wdata[7:0];
        mem[{mem_addr[9:1], 1'b1}] <= mem_wdata[15:8];
      end else begin
        mem[mem_addr[9:0]] <= mem_wdata[7:0];
      end
      if (wcnt < 64) wlog[wcnt] <= mem_addr[9:0];
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_tmr(input int i);
    @(negedge clk); trig_tmr[i] = 1'b1;
    @(negedge clk); trig_tmr[i] = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = busy ? 1 : 0;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      if (busy) cyc++;
    end
  endtask

  task automatic setup(input int s, input int d, input int n, input int b, input int c);
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, n); wr(3'd3, n); wr(3'd4, b); wr(3'd5, c);
    wcnt = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d);
      chk($sformatf("R1 reg %0d after reset", a), d, 32'd0);
    end
    chk("R1 busy/irq/mem idle", {busy, irq, mem_re, mem_we}, 4'b0000);
  endtask

  task automatic t_byte_blockdst;
    logic [31:0] d; int cyc;
    setup(32'h100, 32'h200, 4, 2, 32'h02B);
    pulse_tmr(0);
    wait_idle(cyc);
    chk("R2 busy cycles per block of 4", cyc, 8);
    chk("R2 writes per block", wcnt, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R3 byte increment dst sequence", 32'(wlog[k]), 32'h200 + k);
      chk("R2 copied byte", 32'(mem[10'h200 + k]), 32'(orig[10'h100 + k]));
    end
    rd(3'd0, d); chk("R5 non-block src keeps stepped value", d, 32'h104);
    rd(3'd1, d); chk("R5 R6 block dst restored", d, 32'h200);
    rd(3'd2, d); chk("R4 unit count reloaded", d, 32'd4);
    rd(3'd4, d); chk("R7 block count decremented", d, 32'd1);
    rd(3'd5, d); chk("R7 enable kept while blocks remain", d[0], 1'b1);
    chk("R8 no irq before job end", irq, 1'b0);
    pulse_tmr(0);
    wait_idle(cyc);
    for (int k = 0; k < 4; k++)
      chk("R5 second block overwrites block area", 32'(mem[10'h200 + k]), 32'(orig[10'h104 + k]));
    rd(3'd0, d); chk("R5 src continues", d, 32'h108);
    rd(3'd4, d); chk("R7 block count zero", d, 32'd0);
    rd(3'd5, d); chk("R8 enable cleared by hardware", d[0], 1'b0);
    chk("R8 irq raised with ie set", irq, 1'b1);
    pulse_tmr(0);
    chk("R11 trigger ignored while disabled", busy, 1'b0);
    repeat (5) @(negedge clk);
    chk("R9 irq held", irq, 1'b1);
    wr(3'd5, 32'h02A);
    chk("R9 irq cleared by control write", irq, 1'b0);
  endtask

  task automatic t_word_blocksrc_ext;
    logic [31:0] d; int cyc;
    setup(32'h140, 32'h300, 3, 2, 32'h4CD);
    @(negedge clk); trig_ext_n = 1'b0;
    @(negedge clk);
    wait_idle(cyc);
    chk("R10 external falling edge starts burst", cyc, 6);
    chk("R3 word decrement dst 0", 32'(wlog[0]), 32'h300);
    chk("R3 word decrement dst 1", 32'(wlog[1]), 32'h2FE);
    chk("R3 word decrement dst 2", 32'(wlog[2]), 32'h2FC);
    rd(3'd0, d); chk("R6 block src restored", d, 32'h140);
    rd(3'd1, d); chk("R6 dst keeps stepping", d, 32'h2FA);
    repeat (4) @(negedge clk);
    chk("R10 held-low external pin does not retrigger", {busy, 8'(wcnt)}, {1'b0, 8'd3});
    trig_ext_n = 1'b1;
    @(negedge clk); trig_ext_n = 1'b0;
    @(negedge clk);
    wait_idle(cyc);
    trig_ext_n = 1'b1;
    chk("R3 second block dst", 32'(wlog[5]), 32'h2F6);
    chk("R5 word data repeated from restored src",
        {24'd0, mem[10'h2F7], mem[10'h2F6]}, {24'd0, orig[10'h145], orig[10'h144]});
    rd(3'd1, d); chk("R3 final dst", d, 32'h2F4);
    rd(3'd5, d); chk("R8 enable cleared", d[0], 1'b0);
    chk("R8 no irq when ie clear", irq, 1'b0);
  endtask

  task automatic t_hold_and_select;
    logic [31:0] d; int cyc;
    setup(32'h180, 32'h3A0, 3, 1, 32'h213);
    pulse_tmr(1);
    chk("R10 unselected timer ignored", busy, 1'b0);
    pulse_tmr(2);
    wait_idle(cyc);
    chk("R3 hold dst 0", 32'(wlog[0]), 32'h3A0);
    chk("R3 hold dst 2", 32'(wlog[2]), 32'h3A0);
    chk("R3 byte decrement src data", 32'(mem[10'h3A0]), 32'(orig[10'h17E]));
    rd(3'd0, d); chk("R3 src decremented by 3", d, 32'h17D);
    chk("R8 irq single-block job", irq, 1'b1);
    wr(3'd5, 32'h0);
    chk("R9 irq clear", irq, 1'b0);
  endtask

  task automatic t_collision;
    logic [31:0] d; int cyc;
    setup(32'h1C0, 32'h3C0, 2, 3, 32'h329);
    @(negedge clk); trig_tmr[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); trig_tmr[3] = 1'b0;
    @(negedge clk);
    @(negedge clk); trig_tmr[3] = mem_we;
    @(negedge clk); trig_tmr[3] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 retrigger in burst and last write ignored", {busy, 8'(wcnt)}, {1'b0, 8'd2});
    rd(3'd4, d); chk("R11 one block only", d, 32'd2);
    rd(3'd1, d); chk("R5 restore on collision cycle", d, 32'h3C0);
    pulse_tmr(3);
    wait_idle(cyc);
    chk("R7 next trigger runs next block", wcnt, 4);
    chk("R7 next block writes restored area", 32'(wlog[2]), 32'h3C0);
    rd(3'd4, d); chk("R7 block count 1", d, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'(i * 7 + 3) ^ 8'h5A;
      orig[i] = 8'(i * 7 + 3) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_blockdst();
    t_word_blocksrc_ext();
    t_hold_and_select();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule